// File: doc/BRIEF.md
# Custom Glyph Upload Sequencer

This block programs one user-defined character shape into the character-generator memory of a character LCD controller and then puts the controller back into normal display addressing. A single start pulse captures a 3-bit glyph slot and eight 5-bit pixel rows. The block then issues a fixed run of eleven bus accesses to a lower-level bus cycle engine over a request/done handshake. The engine performs the actual enable pulses and returns read data.

The run has four parts. First, a status read fetches the current display-memory address, which the block keeps. Next comes a command that points the controller at the glyph's slot. Then eight row writes follow, top row first, and the controller advances its own pointer after each one. Last, a command sends the controller back to display memory at the address that was kept. A fixed idle gap of `GAP_CYCLES` clock cycles separates each access from the next, so that the controller's execution time of at least 120 µs is met. The default is 30000 cycles, which is 120 µs at 250 MHz.

Top module: `glyph_loader`

## Requirements
- R1: After reset, `busy` and `req` are 0. A `start` sampled while `busy` is 0 raises `busy` and `req` on the next cycle.
- R2: The first access is a read with `req_rs`=0 and `req_rw`=1.
- R3: The second access is a command (`req_rs`=0, `req_rw`=0) with `req_data` = 0x40 + 8 × glyph index. For example, index 3 gives 0x58.
- R4: Accesses three to ten are eight data writes (`req_rs`=1, `req_rw`=0). The first of these carries row 0 (`rows[4:0]`), the top row. Row k is taken from `rows[5k+4:5k]`. The row sits in `req_data[4:0]`, with bit 4 the leftmost pixel, and bits 7..5 are 0.
- R5: The eleventh access is a command with `req_data` = 0x80 OR bits 6..0 of the `rd_data` that was returned with the done of the first read. Bit 7 of that read is discarded.
- R6: After each done except the last, `req` stays low for exactly `GAP_CYCLES` cycles before the next access starts.
- R7: While `req` is high and `done` has not yet come, `req`, `req_rs`, `req_rw` and `req_data` hold steady.
- R8: `busy` falls on the cycle after the done of the eleventh access. `req` is never high while `busy` is low.
- R9: A `start` pulse, or a change of `glyph_idx` or `rows`, that arrives while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an upload (sampled while idle) |
| glyph_idx | input | 3 | Character-generator slot to program |
| rows | input | 40 | Eight 5-bit pixel rows; row k at bits 5k+4..5k |
| busy | output | 1 | High for the whole upload |
| req | output | 1 | Access request to the cycle engine |
| req_rs | output | 1 | Register select: 0 command/status, 1 data |
| req_rw | output | 1 | 1 read, 0 write |
| req_data | output | 8 | Byte to write |
| done | input | 1 | One-cycle completion pulse from the engine |
| rd_data | input | 8 | Read byte, valid with `done` |

## Verification
The hardest case to reach is the one where restore correctness depends on data the block captured ten accesses earlier. That data arrives only through the engine's response to the opening read. The bench therefore acts as the engine itself. It returns a different address on every upload, with bit 7 set on some of them, and it varies the done latency. The restore byte then exposes any wrong capture or any leak of bit 7. A second hard case is a start pulse that arrives in the middle of an upload. Here a fresh start and new inputs are injected while a row write is pending, and the run must finish unchanged.

// File: rtl/glyph_loader.sv
module glyph_loader #(
  parameter int GAP_CYCLES = 30000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  glyph_idx,
  input  logic [39:0] rows,
  output logic        busy,
  output logic        req,
  output logic        req_rs,
  output logic        req_rw,
  output logic [7:0]  req_data,
  input  logic        done,
  input  logic [7:0]  rd_data
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
  localparam logic [3:0] LAST_STEP = 4'd10;

  typedef enum logic [1:0] {IDLE, ACCESS, GAP} st_t;
  st_t st;
  logic [3:0]    step;
  logic [GW-1:0] gcnt;
  logic [2:0]    idx_q;
  logic [4:0]    row_q [8];
  logic [6:0]    addr_q;
  logic [3:0]    rsel;

  assign busy = (st != IDLE);
  assign req  = (st == ACCESS);
  assign rsel = step - 4'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      step   <= '0;
      gcnt   <= '0;
      idx_q  <= '0;
      addr_q <= '0;
      for (int k = 0; k < 8; k++) row_q[k] <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st    <= ACCESS;
          step  <= '0;
          idx_q <= glyph_idx;
          for (int k = 0; k < 8; k++) row_q[k] <= rows[5*k +: 5];
        end
        ACCESS: if (done) begin
          if (step == 4'd0) addr_q <= rd_data[6:0];
          if (step == LAST_STEP) st <= IDLE;
          else begin
            st   <= GAP;
            gcnt <= '0;
            step <= step + 4'd1;
          end
        end
        GAP: begin
          if (gcnt == GAP_LAST) st <= ACCESS;
          gcnt <= gcnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    req_rs   = 1'b0;
    req_rw   = 1'b0;
    req_data = 8'h00;
    if (step == 4'd0) req_rw = 1'b1;
    else if (step == 4'd1) req_data = {2'b01, idx_q, 3'b000};
    else if (step == LAST_STEP) req_data = {1'b1, addr_q};
    else begin
      req_rs   = 1'b1;
      req_data = {3'b000, row_q[rsel[2:0]]};
    end
  end
endmodule

// File: rtl/glyph_loader_chk.sv
module glyph_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       req,
  input logic       req_rs,
  input logic       req_rw,
  input logic [7:0] req_data,
  input logic       done
);
  // R1
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && req));
  // R7
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !done) |=> (req && $stable(req_rs) && $stable(req_rw) && $stable(req_data)));
  // R8
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(req && done));
  // R6
  gap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && done) |=> !req);
  // R4
  row_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_rs) |-> (!req_rw && req_data[7:5] == 3'b000));
endmodule

bind glyph_loader glyph_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .req(req),
  .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data), .done(done)
);

// File: tb/tb_glyph_loader.sv
module tb_glyph_loader;
  localparam int GAP = 5;
  logic clk = 0, rst_n = 0, start = 0, done = 0;
  logic [2:0] glyph_idx = 0;
  logic [39:0] rows = 0;
  logic [7:0] rd_data = 0;
  logic busy, req, req_rs, req_rw;
  logic [7:0] req_data;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  glyph_loader #(.GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .glyph_idx(glyph_idx), .rows(rows),
    .busy(busy), .req(req), .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data),
    .done(done), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic upload(input logic [2:0] ix, input int seed, input logic [7:0] rdv,
                        input int lat, input bit poke);
    logic [4:0] rw [8];
    logic [7:0] exp_d;
    logic exp_rs, exp_rw;
    for (int k = 0; k < 8; k++) rw[k] = 5'((seed + k * 11 + ix * 7) % 32);
    @(negedge clk);
    glyph_idx = ix;
    for (int k = 0; k < 8; k++) rows[5*k +: 5] = rw[k];
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R1 busy", busy, 1);
    for (int a = 0; a <= 10; a++) begin
      int g = 0;
      while (req !== 1'b1 && g < 1000) begin
        @(negedge clk);
        g++;
      end
      if (a > 0) chk(g == GAP, "R6 gap", g, GAP);
      exp_rs = (a >= 2 && a <= 9);
      exp_rw = (a == 0);
      if (a == 1) exp_d = 8'h40 | (8'(ix) << 3);
      else if (a == 10) exp_d = 8'h80 | {1'b0, rdv[6:0]};
      else if (a >= 2) exp_d = {3'b000, rw[a-2]};
      else exp_d = req_data;
      if (a == 0) chk(req_rs === 1'b0 && req_rw === 1'b1, "R2 read", {req_rs, req_rw}, 1);
      else if (a == 1) chk(req_rs === 0 && req_rw === 0 && req_data === exp_d, "R3 cg cmd", req_data, exp_d);
      else if (a == 10) chk(req_rs === 0 && req_rw === 0 && req_data === exp_d, "R5 restore", req_data, exp_d);
      else chk(req_rs === exp_rs && req_rw === exp_rw && req_data === exp_d, "R4 row", req_data, exp_d);
      for (int w = 0; w < lat; w++) begin
        if (poke && a == 4 && w == 0) begin
          start = 1;
          glyph_idx = ~ix;
          rows = ~rows;
        end
        @(negedge clk);
        start = 0;
        chk(req === 1'b1 && busy === 1'b1 && req_data === exp_d && req_rs === exp_rs && req_rw === exp_rw,
            "R7 hold", req_data, exp_d);
      end
      done = 1;
      rd_data = rdv;
      @(negedge clk);
      done = 0;
      rd_data = 8'hxx;
    end
    chk(busy === 1'b0 && req === 1'b0, "R8 end", {busy, req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && req === 1'b0, "R1 reset", {busy, req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && req === 1'b0, "R8 idle", {busy, req}, 0);
    for (int i = 0; i < 8; i++)
      upload(3'(i), i * 5 + 1, 8'((i * 29 + 3) | ((i % 2) << 7)), i % 4, 1'b0);
    upload(3'd3, 17, 8'hA7, 3, 1'b1);      // R9: mid-run start and input change ignored
    upload(3'd6, 0, 8'h7F, 0, 1'b0);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && req === 1'b0, "R9 quiet", {busy, req}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule